// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the tag-compare and data-select path of a two-way set-associative cache. Each set carries one prediction bit that names the way most likely to hit. When a lookup is accepted, only the predicted way's tag is compared and the data multiplexer is already steered to that way. A match returns the word one cycle after acceptance. If it fails, the other way is compared in the next cycle, so a correct hit in the other way costs one extra cycle. If both ways fail, the lookup is a miss.

A refill port installs a block after a miss. The victim is an empty way when one exists. Otherwise it is the way the prediction does not name. The prediction then points at the new block. Three counters tally fast hits, slow hits and misses, so prediction accuracy over a known access sequence can be read off directly. Writes from the processor side and the memory protocol behind the refill are outside this block.

Top module: `wp_cache_lookup`

## Requirements
- R1: After a synchronous active-low reset, every way of every set is empty, every prediction bit names way 0, the three counters are zero, all outcome pulses and `rsp_data` are zero, and both ready outputs are high.
- R2: An address is split as tag (upper bits) / set index (bits OFS_W+SET_W-1 down to OFS_W) / byte offset (low OFS_W bits). The offset takes no part in the lookup, and an equal tag in another set does not match.
- R3: An accepted lookup whose predicted way holds a valid matching tag raises `rsp_fast_hit` for one cycle, on the clock edge that accepts the request, and returns that way's word on `rsp_data`.
- R4: An accepted lookup whose predicted way does not match holds `req_ready` and `fill_ready` low for the following cycle.
- R5: In that following cycle the other way is compared. On a match, `rsp_slow_hit` pulses one clock edge later than a fast hit would, with that way's word. Otherwise `rsp_miss` pulses with `rsp_data` zero.
- R6: At most one of the three outcome pulses is high in any cycle. Each accepted lookup produces exactly one of them, and nothing else produces any. `rsp_data` is zero in every cycle without a hit.
- R7: A slow hit moves the set's prediction to the way that hit, so an immediate repeat of the same lookup is a fast hit. A fast hit leaves the prediction unchanged.
- R8: A refill writes the first empty way (way 0 before way 1). If both ways are valid, it writes the way the prediction does not name, which keeps the predicted block. The prediction then names the written way.
- R9: A refill request takes priority. While `fill_valid` is high, `req_ready` is low, and a lookup request in that cycle is not accepted and produces no outcome.
- R10: Each outcome counter (`cnt_fast`, `cnt_slow`, `cnt_miss`) rises by exactly one in each cycle in which its outcome pulse is high, and holds its value otherwise.
- R11: A refill or a prediction change in one set leaves the contents and prediction of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Byte address to look up |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| fill_valid | input | 1 | Refill request present |
| fill_addr | input | ADDR_W | Address of the block being installed |
| fill_data | input | DATA_W | Word of the block being installed |
| fill_ready | output | 1 | Refill is taken this cycle |
| rsp_fast_hit | output | 1 | Pulse: hit in the predicted way |
| rsp_slow_hit | output | 1 | Pulse: hit in the other way, one cycle later |
| rsp_miss | output | 1 | Pulse: neither way matched |
| rsp_data | output | DATA_W | Word that hit, zero otherwise |
| cnt_fast | output | CNT_W | Number of fast hits |
| cnt_slow | output | CNT_W | Number of slow hits |
| cnt_miss | output | CNT_W | Number of misses |

## Verification
The hardest case to reach is a set with both ways valid where the prediction names the way that does not hold the requested block. Only such a set produces a slow hit and drives the victim choice away from an empty way. The stimulus builds this state through the ports. It installs two blocks in one set, so the prediction follows the second block. It then looks up the first block, refills a third block into that full set, and looks up both survivors and the evicted block. A bench model of tags and prediction bits computes each expected outcome, data word and response cycle, and a monitor compares them in order.

// File: rtl/wp_cache_pkg.sv
// Shared types for the way-predicted lookup path.
// Assumes exactly two ways per set; a way number is one bit.
package wp_cache_pkg;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_FAST = 2'd1,
        OUT_SLOW = 2'd2,
        OUT_MISS = 2'd3
    } outcome_e;

    // Victim choice: first empty way, else the way not predicted.
    function automatic logic pick_victim(input logic [1:0] valid, input logic pred);
        if (!valid[0]) return 1'b0;
        if (!valid[1]) return 1'b1;
        return ~pred;
    endfunction

endpackage

// File: rtl/wp_way_store.sv
// Storage for both ways of every set: valid bit, tag and data word per
// way, plus one prediction bit per set. Two combinational read ports
// (lookup set, refill set), one block write port, one prediction write
// port. Assumes the caller never writes a block and a prediction bit of
// different meaning to the same set in one cycle.
module wp_way_store #(
    parameter int SET_W  = 3,
    parameter int TAG_W  = 11,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [1:0]                   rd_valid,
    output logic [1:0][TAG_W-1:0]        rd_tag,
    output logic [1:0][DATA_W-1:0]       rd_data,
    output logic                         rd_pred,
    input  logic [SET_W-1:0]             fl_set,
    output logic [1:0]                   fl_valid,
    output logic                         fl_pred,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic                         wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         pw_en,
    input  logic [SET_W-1:0]             pw_set,
    input  logic                         pw_val
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] pred_q;

    genvar w;
    generate
        for (w = 0; w < 2; w++) begin : g_way
            logic [SETS-1:0]             valid_q;
            logic [SETS-1:0][TAG_W-1:0]  tag_q;
            logic [SETS-1:0][DATA_W-1:0] data_q;

            // Install a block into this way when it is the chosen victim.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= '0;
                    tag_q   <= '0;
                    data_q  <= '0;
                end else if (wr_en && (wr_way == 1'(w))) begin
                    valid_q[wr_set] <= 1'b1;
                    tag_q[wr_set]   <= wr_tag;
                    data_q[wr_set]  <= wr_data;
                end
            end

            // Read this way at the lookup set and at the refill set.
            always_comb begin
                rd_valid[w] = valid_q[rd_set];
                rd_tag[w]   = tag_q[rd_set];
                rd_data[w]  = data_q[rd_set];
                fl_valid[w] = valid_q[fl_set];
            end
        end
    endgenerate

    // Per-set prediction bit, reset to way 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     pred_q <= '0;
        else if (pw_en) pred_q[pw_set] <= pw_val;
    end

    // Prediction read for both ports.
    always_comb begin
        rd_pred = pred_q[rd_set];
        fl_pred = pred_q[fl_set];
    end
endmodule

// File: rtl/wp_probe_ctrl.sv
// Two-step probe sequencer. An accepted request probes the predicted
// way; a failure holds the request for one more cycle in which the
// other way is probed. Registers the outcome and the selected word.
// Assumes the caller blocks new requests while busy is high.
module wp_probe_ctrl
    import wp_cache_pkg::*;
#(
    parameter int SET_W  = 3,
    parameter int TAG_W  = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              probe_hit,
    input  logic [DATA_W-1:0] probe_data,
    output logic              busy,
    output logic [SET_W-1:0]  held_set,
    output logic [TAG_W-1:0]  held_tag,
    output outcome_e          outcome,
    output logic [DATA_W-1:0] out_data
);
    // Sequence the first and second probe and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            held_set <= '0;
            held_tag <= '0;
            outcome  <= OUT_NONE;
            out_data <= '0;
        end else if (busy) begin
            busy     <= 1'b0;
            outcome  <= probe_hit ? OUT_SLOW : OUT_MISS;
            out_data <= probe_hit ? probe_data : '0;
        end else if (accept) begin
            held_set <= req_set;
            held_tag <= req_tag;
            busy     <= !probe_hit;
            outcome  <= probe_hit ? OUT_FAST : OUT_NONE;
            out_data <= probe_hit ? probe_data : '0;
        end else begin
            outcome  <= OUT_NONE;
            out_data <= '0;
        end
    end
endmodule

// File: rtl/wp_outcome_counters.sv
// One wrapping event counter per outcome class, incremented on the
// cycle its outcome pulse is visible.
module wp_outcome_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    genvar i;
    generate
        for (i = 0; i < NUM; i++) begin : g_cnt
            // Count pulses of outcome class i.
            always_ff @(posedge clk) begin
                if (!rst_n)      cnt[i] <= '0;
                else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/wp_cache_lookup.sv
// Way-predicted two-way lookup path. Splits addresses into
// tag/set/offset, steers the probe to the predicted way, retries the
// other way one cycle later, updates the prediction on a slow hit and
// installs refill blocks with victim choice. Refill has priority over
// lookup and is held off while a second probe is in progress.
module wp_cache_lookup
    import wp_cache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SET_W  = 3,
    parameter int OFS_W  = 2,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fill_ready,
    output logic              rsp_fast_hit,
    output logic              rsp_slow_hit,
    output logic              rsp_miss,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  cnt_fast,
    output logic [CNT_W-1:0]  cnt_slow,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int TAG_W = ADDR_W - SET_W - OFS_W;

    logic [SET_W-1:0]        req_set, fill_set, look_set, held_set, pw_set;
    logic [TAG_W-1:0]        req_tag, fill_tag, look_tag, held_tag;
    logic [1:0]              rd_valid, fl_valid;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic                    rd_pred, fl_pred;
    logic                    busy, accept, fill_go, probe_way, probe_hit;
    logic                    victim, pw_en, pw_val;
    logic [DATA_W-1:0]       probe_data;
    outcome_e                outcome;
    logic [2:0][CNT_W-1:0]   cnt_all;

    // Address field split for both request ports.
    always_comb begin
        req_set  = req_addr[OFS_W +: SET_W];
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        fill_set = fill_addr[OFS_W +: SET_W];
        fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    end

    // Handshake: refill wins; nothing is taken during the second probe.
    always_comb begin
        fill_ready = !busy;
        req_ready  = !busy && !fill_valid;
        fill_go    = fill_valid && !busy;
        accept     = req_valid && req_ready;
    end

    // Probe steering: predicted way first, other way on the retry.
    always_comb begin
        look_set   = busy ? held_set : req_set;
        look_tag   = busy ? held_tag : req_tag;
        probe_way  = busy ? !rd_pred : rd_pred;
        probe_hit  = rd_valid[probe_way] && (rd_tag[probe_way] == look_tag);
        probe_data = rd_data[probe_way];
    end

    // Prediction write: slow hit retargets, refill points at new block.
    always_comb begin
        victim = pick_victim(fl_valid, fl_pred);
        pw_en  = fill_go || (busy && probe_hit);
        pw_set = busy ? held_set : fill_set;
        pw_val = busy ? probe_way : victim;
    end

    wp_way_store #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (look_set),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_pred  (rd_pred),
        .fl_set   (fill_set),
        .fl_valid (fl_valid),
        .fl_pred  (fl_pred),
        .wr_en    (fill_go),
        .wr_set   (fill_set),
        .wr_way   (victim),
        .wr_tag   (fill_tag),
        .wr_data  (fill_data),
        .pw_en    (pw_en),
        .pw_set   (pw_set),
        .pw_val   (pw_val)
    );

    wp_probe_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_set    (req_set),
        .req_tag    (req_tag),
        .probe_hit  (probe_hit),
        .probe_data (probe_data),
        .busy       (busy),
        .held_set   (held_set),
        .held_tag   (held_tag),
        .outcome    (outcome),
        .out_data   (rsp_data)
    );

    // Outcome decode into the three response pulses.
    always_comb begin
        rsp_fast_hit = (outcome == OUT_FAST);
        rsp_slow_hit = (outcome == OUT_SLOW);
        rsp_miss     = (outcome == OUT_MISS);
    end

    wp_outcome_counters #(.NUM(3), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   ({rsp_miss, rsp_slow_hit, rsp_fast_hit}),
        .cnt   (cnt_all)
    );

    // Counter fan-out.
    always_comb begin
        cnt_fast = cnt_all[0];
        cnt_slow = cnt_all[1];
        cnt_miss = cnt_all[2];
    end
endmodule

// File: rtl/wp_cache_lookup_chk.sv
// Port-level temporal checks for wp_cache_lookup, attached by bind.
module wp_cache_lookup_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic              rsp_fast_hit,
    input logic              rsp_slow_hit,
    input logic              rsp_miss,
    input logic [DATA_W-1:0] rsp_data,
    input logic [CNT_W-1:0]  cnt_fast,
    input logic [CNT_W-1:0]  cnt_slow,
    input logic [CNT_W-1:0]  cnt_miss
);
    // R6: never two outcomes at once
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_fast_hit, rsp_slow_hit, rsp_miss}));

    // R4: accepted lookup is either a fast hit or blocks the next cycle
    a_r4_retry_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_fast_hit || (!fill_ready && !req_ready)));

    // R5: a blocked cycle is followed by slow hit or miss
    a_r5_retry_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_ready |=> (rsp_slow_hit || rsp_miss));

    // R6: no hit means a zero data word
    a_r6_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fast_hit || rsp_slow_hit) |-> (rsp_data == '0));

    // R9: refill request blocks lookup acceptance
    a_r9_fill_priority: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !req_ready);

    // R10: counters step by one on their pulse, else hold
    a_r10_fast_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fast_hit |=> (cnt_fast == $past(cnt_fast) + 1'b1));
    a_r10_slow_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_slow_hit |=> (cnt_slow == $past(cnt_slow) + 1'b1));
    a_r10_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_miss |=> $stable(cnt_miss));
endmodule

bind wp_cache_lookup wp_cache_lookup_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .fill_valid   (fill_valid),
    .fill_ready   (fill_ready),
    .rsp_fast_hit (rsp_fast_hit),
    .rsp_slow_hit (rsp_slow_hit),
    .rsp_miss     (rsp_miss),
    .rsp_data     (rsp_data),
    .cnt_fast     (cnt_fast),
    .cnt_slow     (cnt_slow),
    .cnt_miss     (cnt_miss)
);

// File: tb/tb_wp_cache_lookup.sv
// Scoreboard bench: the driver models tags and predictions, queues the
// expected outcome, word and response cycle; the monitor compares.
module tb_wp_cache_lookup;
    localparam int ADDR_W = 16;
    localparam int SET_W  = 3;
    localparam int OFS_W  = 2;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int TAG_W  = ADDR_W - SET_W - OFS_W;
    localparam int SETS   = 1 << SET_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic req_ready, fill_ready, rsp_fast_hit, rsp_slow_hit, rsp_miss;
    logic [DATA_W-1:0] rsp_data;
    logic [CNT_W-1:0] cnt_fast, cnt_slow, cnt_miss;

    always #10 clk = ~clk;   // 50 MHz

    wp_cache_lookup #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFS_W(OFS_W),
                      .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

    typedef struct {
        int          kind;   // 1 fast, 2 slow, 3 miss
        logic [31:0] data;
        int          stamp;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0, n_bad = 0, cyc = 0;
    int t_fast = 0, t_slow = 0, t_miss = 0;
    bit done = 0;

    bit               m_valid [2][SETS];
    logic [TAG_W-1:0] m_tag   [2][SETS];
    logic [31:0]      m_data  [2][SETS];
    bit               m_pred  [SETS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int ofs);
        return {TAG_W'(tag), SET_W'(set), OFS_W'(ofs)};
    endfunction

    // Monitor: pop and compare each visible outcome.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int kind;
            kind = rsp_fast_hit ? 1 : rsp_slow_hit ? 2 : rsp_miss ? 3 : 0;
            check("R6 single outcome", 64'(rsp_fast_hit + rsp_slow_hit + rsp_miss) <= 1, 1);
            if (kind == 0) begin
                if (rsp_data !== '0) check("R6 idle data zero", rsp_data, 0);
            end else if (exp_q.size() == 0) begin
                check("R6/R9 unexpected outcome", kind, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.rq, " kind"}, kind, e.kind);
                check({e.rq, " data"}, rsp_data, e.data);
                check({e.rq, " cycle"}, cyc, e.stamp);
            end
        end
    end

    task automatic do_lookup(input logic [ADDR_W-1:0] a, input string rq);
        exp_t e;
        int s; logic [TAG_W-1:0] t; bit p;
        s = int'(a[OFS_W +: SET_W]); t = a[ADDR_W-1 -: TAG_W]; p = m_pred[s];
        @(negedge clk);
        e.rq = rq;
        if (m_valid[p][s] && m_tag[p][s] == t) begin
            e.kind = 1; e.data = m_data[p][s]; e.stamp = cyc + 1; t_fast++;
        end else if (m_valid[!p][s] && m_tag[!p][s] == t) begin
            e.kind = 2; e.data = m_data[!p][s]; e.stamp = cyc + 2; t_slow++;
            m_pred[s] = !p;
        end else begin
            e.kind = 3; e.data = 0; e.stamp = cyc + 2; t_miss++;
        end
        exp_q.push_back(e);
        check("R9 ready before lookup", req_ready, 1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (e.kind != 1) begin
            check("R4 req_ready low on retry", req_ready, 0);
            check("R4 fill_ready low on retry", fill_ready, 0);
            @(negedge clk);
        end
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] a, input logic [31:0] d, input bit with_req);
        int s; bit v;
        s = int'(a[OFS_W +: SET_W]);
        v = !m_valid[0][s] ? 1'b0 : !m_valid[1][s] ? 1'b1 : !m_pred[s];
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        if (with_req) begin
            req_valid = 1'b1; req_addr = a;
        end
        #1;
        check("R8 fill_ready", fill_ready, 1);
        if (with_req) check("R9 req_ready low during fill", req_ready, 0);
        m_valid[v][s] = 1'b1; m_tag[v][s] = a[ADDR_W-1 -: TAG_W];
        m_data[v][s] = d; m_pred[s] = v;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_pred[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_valid[w][s] = 0; m_tag[w][s] = '0; m_data[w][s] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1 fast", rsp_fast_hit, 0);
        check("R1 slow", rsp_slow_hit, 0);
        check("R1 miss", rsp_miss, 0);
        check("R1 data", rsp_data, 0);
        check("R1 req_ready", req_ready, 1);
        check("R1 fill_ready", fill_ready, 1);
        check("R1 counters", {cnt_fast, cnt_slow, cnt_miss}, 0);

        do_lookup(mk(1, 2, 0), "R1 R5 cold miss");
        do_fill(mk(1, 2, 0), 32'hA000_0001, 0);                 // way0
        do_lookup(mk(1, 2, 3), "R2 R3 offset ignored fast hit");
        do_fill(mk(2, 2, 0), 32'hB000_0002, 0);                 // way1, pred 1
        do_lookup(mk(2, 2, 1), "R8 R3 new block predicted");
        do_lookup(mk(1, 2, 0), "R5 slow hit other way");
        do_lookup(mk(1, 2, 2), "R7 repeat becomes fast");
        do_fill(mk(3, 2, 0), 32'hC000_0003, 0);                 // evicts way1
        do_lookup(mk(3, 2, 0), "R8 refill into non-predicted way");
        do_lookup(mk(1, 2, 0), "R8 predicted block kept");
        do_lookup(mk(2, 2, 0), "R8 victim evicted miss");
        do_fill(mk(1, 5, 0), 32'hD000_0005, 0);
        do_lookup(mk(1, 2, 0), "R11 other set prediction kept");
        do_lookup(mk(1, 5, 0), "R2 R11 same tag other set");
        do_fill(mk(4, 5, 0), 32'hE000_0004, 1);                 // R9 collision
        @(negedge clk);
        do_lookup(mk(4, 5, 0), "R9 R8 fill taken over lookup");
        do_lookup(mk(5, 5, 0), "R5 tag mismatch miss");
        do_lookup(mk(1, 5, 0), "R7 slow hit retargets");
        repeat (3) @(negedge clk);
        check("R10 fast count", cnt_fast, t_fast);
        check("R10 slow count", cnt_slow, t_slow);
        check("R10 miss count", cnt_miss, t_miss);
        check("R6 all outcomes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule